// File: doc/BRIEF.md
# ECC Engine Register Front-End

This block sits between a 32-bit memory-mapped bus slave port and a block-oriented BCH error-correction engine. Software programs a control word (enable, initialise, encode/decode select, correction strength) and a count word (message size and parity size in bytes). It then pushes the message through a data port, followed by the parity bytes when decoding. The front-end forwards those bytes to the engine as a lane-packed stream and counts them. When the programmed total is reached it starts the engine once. When the engine reports completion, the front-end keeps the engine's parity bytes, error reports and flags for software to read. It raises an interrupt from a write-one-to-clear status word that is gated by an enable mask.

The sequencing is done by a four-state machine. ST_OFF is entered whenever the enable bit is 0. ST_LOAD is entered from any state when the init bit is seen with enable set; in this state bytes are accepted. ST_RUN is entered from ST_LOAD when the byte count reaches its target. ST_DONE is entered from ST_RUN on the engine's done strobe and held until the next init. The engine arithmetic is outside the block. It writes parity bytes and error reports into the front-end by index during ST_RUN, then pulses done together with its flags.

Top module: `ecc_regfront`

## Requirements
- R1: The control word at byte address 0x000 holds enable in bit 0, init in bit 1, encode select (1 = encode, 0 = decode) in bit 2 and a 7-bit strength in bits 10:4. Writes honour the byte enables, unused bits read 0, and the encode bit and strength are presented on eng_encode and eng_strength.
- R2: A write to 0x008 clears every control bit whose written value is 1 (within enabled bytes) and leaves the other bits unchanged.
- R3: The init bit reads back as 0 one cycle after it was set. Its action clears the byte counter, all stored parity bytes and all stored error reports, and puts the block in ST_LOAD if enable is 1.
- R4: The count word at 0x00C holds the message size in bits 10:0 and the parity size in bits 22:16, and reads back with other bits 0.
- R5: In ST_LOAD, a data-port write (0x010) with all four byte enables forwards four bytes, lane 0 first. A write with exactly one byte enable forwards that lane's byte alone in eng_data[7:0]. Any other byte-enable pattern forwards nothing.
- R6: The target is the message size when encoding and the message size plus the parity size when decoding. Bytes beyond the target are dropped from a word write. eng_start pulses for one cycle in the cycle after the target is reached. Later data writes forward nothing until the next init.
- R7: Parity bytes are read as little-endian words from 0x014 upward. Byte k is in word k/4, lane k%4, and bytes never written by the engine read 0.
- R8: The status word at 0x184 has bit 0 errors found, bit 1 uncorrectable, bit 2 encode finished, bit 3 decode finished, bits 22:16 corrected-bit total and bits 30:24 report count. These are set from the engine on done in ST_RUN, and each bit is cleared by writing 1 to it.
- R9: Error report j is read at 0x084 + 4j, with the 16-bit XOR mask in bits 31:16 and the halfword index in bits 10:0.
- R10: While enable is 0 the block is in ST_OFF and data-port writes forward nothing.
- R11: irq is the OR over all bits of status AND enable mask. The mask reads at 0x190, is set by writing 1s to 0x188 and is cleared by writing 1s to 0x18C.
- R12: After reset, control, count, status and the enable mask read 0, irq is low and no stream byte is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte address; writes need bits 1:0 = 0 |
| bus_we | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_encode | output | 1 | 1 = encode, 0 = decode |
| eng_strength | output | 7 | Correction strength |
| eng_valid | output | 1 | Stream bytes present this cycle |
| eng_data | output | 32 | Stream bytes, lane 0 first |
| eng_nbytes | output | 3 | Number of valid low lanes (1..4) |
| eng_par_we | input | 1 | Engine parity byte write |
| eng_par_idx | input | 7 | Parity byte index |
| eng_par_byte | input | 8 | Parity byte value |
| eng_rep_we | input | 1 | Engine error report write |
| eng_rep_idx | input | 6 | Error report slot |
| eng_rep_mask | input | 16 | Halfword XOR mask |
| eng_rep_pos | input | 11 | Halfword index |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 1 | Errors found |
| eng_uncor | input | 1 | Uncorrectable |
| eng_fixed | input | 7 | Corrected-bit total |
| eng_nrep | input | 7 | Valid report count |

## Verification
On every cycle the assertions check the following: the init bit drops on its own, the stream is active only in ST_LOAD and never after the target is reached, eng_start is followed by ST_RUN, an init leaves the result storage empty, write-one-to-clear works on the error flag, and irq stays low with an empty mask. Only the directed scenarios can show the values themselves: byte order and clipping on the stream, the little-endian parity packing with a partial last word, the layout of status fields and report words, and the exact readback of the control and count words.

// File: rtl/ecc_rf_pkg.sv
package ecc_rf_pkg;

    // word offsets (byte address / 4)
    localparam logic [6:0] W_CTRL  = 7'd0;
    localparam logic [6:0] W_CCLR  = 7'd2;
    localparam logic [6:0] W_CNT   = 7'd3;
    localparam logic [6:0] W_DATA  = 7'd4;
    localparam logic [6:0] W_PAR0  = 7'd5;
    localparam logic [6:0] W_REP0  = 7'd33;
    localparam logic [6:0] W_STAT  = 7'd97;
    localparam logic [6:0] W_IESET = 7'd98;
    localparam logic [6:0] W_IECLR = 7'd99;
    localparam logic [6:0] W_IE    = 7'd100;

    localparam int B_EN   = 0;
    localparam int B_INIT = 1;
    localparam int B_ENC  = 2;

    localparam logic [31:0] CTRL_MASK = 32'h0000_07F7;
    localparam logic [31:0] CNT_MASK  = 32'h007F_07FF;
    localparam logic [31:0] STAT_MASK = 32'h7F7F_000F;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } rf_state_t;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/ecc_rf_feed.sv
module ecc_rf_feed #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic             wr,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] target,
    output logic             reached,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic [2:0]       out_nbytes
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] room;
    logic [2:0]       nb_raw;
    logic [7:0]       lane;

    assign reached = (cnt_q >= target);

    always_comb begin
        nb_raw = 3'd0;
        lane   = 8'h00;
        if (be == 4'hF) begin
            nb_raw = 3'd4;
        end else if ($onehot(be)) begin
            nb_raw = 3'd1;
            for (int i = 0; i < 4; i++) begin
                if (be[i]) lane = wdata[8*i +: 8];
            end
        end
        room = reached ? '0 : (target - cnt_q);
        out_nbytes = (CNT_W'(nb_raw) > room) ? room[2:0] : nb_raw;
        out_valid  = accept && wr && (out_nbytes != 3'd0);
        out_data   = 32'h0;
        if (nb_raw == 3'd1) begin
            out_data[7:0] = lane;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (3'(i) < out_nbytes) out_data[8*i +: 8] = wdata[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clear)     cnt_q <= '0;
        else if (out_valid) cnt_q <= cnt_q + CNT_W'(out_nbytes);
    end

    // R6
    no_feed_past_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reached |-> !out_valid);

endmodule

// File: rtl/ecc_rf_results.sv
module ecc_rf_results #(
    parameter int PAR_BYTES = 112,
    parameter int REP_DEPTH = 64,
    parameter int RI_W      = $clog2(REP_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            par_we,
    input  logic [6:0]      par_idx,
    input  logic [7:0]      par_byte,
    input  logic            rep_we,
    input  logic [RI_W-1:0] rep_idx,
    input  logic [15:0]     rep_mask,
    input  logic [10:0]     rep_pos,
    input  logic [6:0]      par_rd_word,
    output logic [31:0]     par_rd_data,
    input  logic [6:0]      rep_rd_idx,
    output logic [31:0]     rep_rd_data
);
    logic [7:0]  par_q [PAR_BYTES];
    logic [26:0] rep_q [REP_DEPTH];

    genvar g;
    generate
        for (g = 0; g < PAR_BYTES; g++) begin : g_par
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 par_q[g] <= 8'h00;
                else if (clear)                             par_q[g] <= 8'h00;
                else if (par_we && (int'(par_idx) == g))    par_q[g] <= par_byte;
            end
        end
        for (g = 0; g < REP_DEPTH; g++) begin : g_rep
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 rep_q[g] <= '0;
                else if (clear)                             rep_q[g] <= '0;
                else if (rep_we && (int'(rep_idx) == g))    rep_q[g] <= {rep_mask, rep_pos};
            end
        end
    endgenerate

    always_comb begin
        par_rd_data = 32'h0;
        for (int b = 0; b < 4; b++) begin
            if ((int'(par_rd_word) * 4 + b) < PAR_BYTES)
                par_rd_data[8*b +: 8] = par_q[int'(par_rd_word) * 4 + b];
        end
        rep_rd_data = 32'h0;
        if (int'(rep_rd_idx) < REP_DEPTH)
            rep_rd_data = {rep_q[int'(rep_rd_idx)][26:11], 5'b0, rep_q[int'(rep_rd_idx)][10:0]};
    end

    // R3
    results_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (par_q[0] == 8'h00) && (rep_q[0] == '0));

endmodule

// File: rtl/ecc_rf_status.sv
module ecc_rf_status
    import ecc_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        done,
    input  logic        enc,
    input  logic        eng_err,
    input  logic        eng_uncor,
    input  logic [6:0]  eng_fixed,
    input  logic [6:0]  eng_nrep,
    input  logic [31:0] stat_w1c,
    input  logic [31:0] ie_set,
    input  logic [31:0] ie_clr,
    output logic [31:0] status,
    output logic [31:0] ie,
    output logic        irq
);
    logic [31:0] set_bits;

    always_comb begin
        set_bits = 32'h0;
        if (done) begin
            if (enc) begin
                set_bits[2] = 1'b1;
            end else begin
                set_bits[3]     = 1'b1;
                set_bits[0]     = eng_err;
                set_bits[1]     = eng_uncor;
                set_bits[22:16] = eng_fixed;
                set_bits[30:24] = eng_nrep;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 32'h0;
            ie     <= 32'h0;
        end else begin
            if (done && !enc)
                status <= ({status[31:23], 7'h0, status[15:0]} & ~{1'b0, 7'h7F, 24'h0} & ~stat_w1c)
                          | set_bits;
            else
                status <= (status & ~stat_w1c & STAT_MASK) | set_bits;
            ie <= ((ie | ie_set) & ~ie_clr) & STAT_MASK;
        end
    end

    assign irq = |(status & ie);

    // R8
    w1c_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1c[0] && !done) |=> !status[0]);

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 32'h0) |-> !irq);

endmodule

// File: rtl/ecc_regfront.sv
module ecc_regfront
    import ecc_rf_pkg::*;
#(
    parameter int PAR_BYTES = 112,
    parameter int REP_DEPTH = 64,
    parameter int RI_W      = $clog2(REP_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [8:0]      bus_addr,
    input  logic            bus_we,
    input  logic [3:0]      bus_be,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq,
    output logic            eng_start,
    output logic            eng_encode,
    output logic [6:0]      eng_strength,
    output logic            eng_valid,
    output logic [31:0]     eng_data,
    output logic [2:0]      eng_nbytes,
    input  logic            eng_par_we,
    input  logic [6:0]      eng_par_idx,
    input  logic [7:0]      eng_par_byte,
    input  logic            eng_rep_we,
    input  logic [RI_W-1:0] eng_rep_idx,
    input  logic [15:0]     eng_rep_mask,
    input  logic [10:0]     eng_rep_pos,
    input  logic            eng_done,
    input  logic            eng_err,
    input  logic            eng_uncor,
    input  logic [6:0]      eng_fixed,
    input  logic [6:0]      eng_nrep
);
    localparam int PAR_WORDS = (PAR_BYTES + 3) / 4;
    localparam int CNT_W     = 12;

    rf_state_t      state_q, state_d;
    logic [31:0]    ctrl_q, cnt_reg_q;
    logic [6:0]     word;
    logic           wr_ok, en, init;
    logic [31:0]    wmask;
    logic [CNT_W-1:0] target;
    logic           reached, accept, run_ok;
    logic [31:0]    status, ie, par_rd, rep_rd;
    logic [6:0]     par_word, rep_slot;

    assign word   = bus_addr[8:2];
    assign wr_ok  = bus_we && (bus_addr[1:0] == 2'b00);
    assign wmask  = lane_mask(bus_be);
    assign en     = ctrl_q[B_EN];
    assign init   = ctrl_q[B_INIT];
    assign target = ctrl_q[B_ENC] ? CNT_W'(cnt_reg_q[10:0])
                                  : CNT_W'(cnt_reg_q[10:0]) + CNT_W'(cnt_reg_q[22:16]);

    // control and count registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= 32'h0;
            cnt_reg_q <= 32'h0;
        end else begin
            if (wr_ok && word == W_CTRL)
                ctrl_q <= (((ctrl_q & ~(32'h1 << B_INIT)) & ~wmask) | (bus_wdata & wmask)) & CTRL_MASK;
            else if (wr_ok && word == W_CCLR)
                ctrl_q <= ctrl_q & ~(bus_wdata & wmask) & ~(32'h1 << B_INIT);
            else
                ctrl_q <= ctrl_q & ~(32'h1 << B_INIT);
            if (wr_ok && word == W_CNT)
                cnt_reg_q <= ((cnt_reg_q & ~wmask) | (bus_wdata & wmask)) & CNT_MASK;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else if (init) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_LOAD: if (reached)  state_d = ST_RUN;
                ST_RUN:  if (eng_done) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state outputs
    always_comb begin
        accept    = 1'b0;
        run_ok    = 1'b0;
        eng_start = 1'b0;
        if (en && !init) begin
            unique case (state_q)
                ST_LOAD: begin
                    accept    = 1'b1;
                    eng_start = reached;
                end
                ST_RUN:  run_ok = 1'b1;
                default: ;
            endcase
        end
    end

    assign eng_encode   = ctrl_q[B_ENC];
    assign eng_strength = ctrl_q[10:4];

    ecc_rf_feed #(.CNT_W(CNT_W)) feed_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (init),
        .accept     (accept),
        .wr         (wr_ok && word == W_DATA),
        .be         (bus_be),
        .wdata      (bus_wdata),
        .target     (target),
        .reached    (reached),
        .out_valid  (eng_valid),
        .out_data   (eng_data),
        .out_nbytes (eng_nbytes)
    );

    assign par_word = word - W_PAR0;
    assign rep_slot = word - W_REP0;

    ecc_rf_results #(.PAR_BYTES(PAR_BYTES), .REP_DEPTH(REP_DEPTH), .RI_W(RI_W)) res_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (init),
        .par_we      (eng_par_we && run_ok),
        .par_idx     (eng_par_idx),
        .par_byte    (eng_par_byte),
        .rep_we      (eng_rep_we && run_ok),
        .rep_idx     (eng_rep_idx),
        .rep_mask    (eng_rep_mask),
        .rep_pos     (eng_rep_pos),
        .par_rd_word (par_word),
        .par_rd_data (par_rd),
        .rep_rd_idx  (rep_slot),
        .rep_rd_data (rep_rd)
    );

    ecc_rf_status stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (eng_done && run_ok),
        .enc       (ctrl_q[B_ENC]),
        .eng_err   (eng_err),
        .eng_uncor (eng_uncor),
        .eng_fixed (eng_fixed),
        .eng_nrep  (eng_nrep),
        .stat_w1c  ((wr_ok && word == W_STAT)  ? (bus_wdata & wmask) : 32'h0),
        .ie_set    ((wr_ok && word == W_IESET) ? (bus_wdata & wmask) : 32'h0),
        .ie_clr    ((wr_ok && word == W_IECLR) ? (bus_wdata & wmask) : 32'h0),
        .status    (status),
        .ie        (ie),
        .irq       (irq)
    );

    // read mux
    always_comb begin
        bus_rdata = 32'h0;
        if (word >= W_PAR0 && int'(word) < int'(W_PAR0) + PAR_WORDS)
            bus_rdata = par_rd;
        else if (word >= W_REP0 && int'(word) < int'(W_REP0) + REP_DEPTH)
            bus_rdata = rep_rd;
        else if (word == W_CTRL) bus_rdata = ctrl_q;
        else if (word == W_CNT)  bus_rdata = cnt_reg_q;
        else if (word == W_STAT) bus_rdata = status;
        else if (word == W_IE)   bus_rdata = ie;
    end

    // R3
    init_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init && !(wr_ok && word == W_CTRL && bus_be[0] && bus_wdata[B_INIT])) |=> !init);

    // R10
    stream_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> (state_q == ST_LOAD && en));

    // R6
    start_then_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> state_q == ST_RUN);

endmodule

// File: tb/ecc_regfront_tb_top.sv
module ecc_regfront_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start, eng_encode, eng_valid;
    logic [6:0]  eng_strength;
    logic [31:0] eng_data;
    logic [2:0]  eng_nbytes;
    logic        eng_par_we = 1'b0;
    logic [6:0]  eng_par_idx = '0;
    logic [7:0]  eng_par_byte = '0;
    logic        eng_rep_we = 1'b0;
    logic [5:0]  eng_rep_idx = '0;
    logic [15:0] eng_rep_mask = '0;
    logic [10:0] eng_rep_pos = '0;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_uncor = 1'b0;
    logic [6:0]  eng_fixed = '0, eng_nrep = '0;

    always #5 clk = ~clk;

    ecc_regfront dut_i (.*);

    int total = 0;
    int bad = 0;
    logic [7:0] cap [512];
    int ncap = 0;
    int nstart = 0;

    always @(negedge clk) begin
        if (eng_valid)
            for (int i = 0; i < int'(eng_nbytes); i++) begin
                cap[ncap] = eng_data[8*i +: 8];
                ncap++;
            end
        if (eng_start) nstart++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic eng_par(input int idx, input logic [7:0] b);
        @(posedge clk); #1;
        eng_par_we = 1'b1; eng_par_idx = 7'(idx); eng_par_byte = b;
        @(posedge clk); #1;
        eng_par_we = 1'b0;
    endtask

    task automatic eng_rep(input int idx, input logic [15:0] m, input logic [10:0] p);
        @(posedge clk); #1;
        eng_rep_we = 1'b1; eng_rep_idx = 6'(idx); eng_rep_mask = m; eng_rep_pos = p;
        @(posedge clk); #1;
        eng_rep_we = 1'b0;
    endtask

    task automatic eng_fin(input logic e, input logic u, input logic [6:0] f, input logic [6:0] n);
        @(posedge clk); #1;
        eng_done = 1'b1; eng_err = e; eng_uncor = u; eng_fixed = f; eng_nrep = n;
        @(posedge clk); #1;
        eng_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(9'h000, v); chk("R12 ctrl", v, 32'h0);
        rd(9'h00C, v); chk("R12 count", v, 32'h0);
        rd(9'h184, v); chk("R12 status", v, 32'h0);
        rd(9'h190, v); chk("R12 ie", v, 32'h0);
        chk("R12 irq", {31'h0, irq}, 32'h0);
        chk("R12 no stream", ncap, 0);
    endtask

    task automatic t_encode();
        logic [31:0] v;
        int b0, s0;
        logic [7:0] exp_b [10] = '{8'h11,8'h22,8'h33,8'h44,8'h55,8'h66,8'h77,8'h88,8'h99,8'hAA};
        wr(9'h00C, 4'hF, 32'h0007_000A);
        rd(9'h00C, v); chk("R4 count readback", v, 32'h0007_000A);
        b0 = ncap; s0 = nstart;
        wr(9'h000, 4'hF, 32'h0000_0037);
        chk("R1 encode out", {31'h0, eng_encode}, 32'h1);
        chk("R1 strength out", {25'h0, eng_strength}, 32'h3);
        wr(9'h010, 4'hF, 32'h4433_2211);
        wr(9'h010, 4'hF, 32'h8877_6655);
        wr(9'h010, 4'b0011, 32'h0000_FFFF);
        chk("R5 two-lane write dropped", ncap - b0, 8);
        wr(9'h010, 4'b0001, 32'h0000_0099);
        chk("R6 no start early", nstart - s0, 0);
        wr(9'h010, 4'b0100, 32'h00AA_0000);
        idle(2);
        chk("R6 one start", nstart - s0, 1);
        chk("R5 byte count", ncap - b0, 10);
        for (int i = 0; i < 10; i++) chk("R5 stream byte", {24'h0, cap[b0+i]}, {24'h0, exp_b[i]});
        wr(9'h010, 4'hF, 32'hDEAD_BEEF);
        chk("R6 extra write ignored", ncap - b0, 10);
        rd(9'h000, v); chk("R3 init self-cleared", v, 32'h0000_0035);
        for (int i = 0; i < 7; i++) eng_par(i, 8'(8'h30 + i));
        eng_fin(1'b0, 1'b0, 7'd0, 7'd0);
        rd(9'h014, v); chk("R7 parity word0", v, 32'h3332_3130);
        rd(9'h018, v); chk("R7 parity partial word1", v, 32'h0036_3534);
        rd(9'h01C, v); chk("R7 parity word2 empty", v, 32'h0);
        rd(9'h184, v); chk("R8 encode finished", v, 32'h0000_0004);
    endtask

    task automatic t_clip_init();
        logic [31:0] v;
        int b0, s0;
        wr(9'h00C, 4'hF, 32'h0000_0006);
        b0 = ncap; s0 = nstart;
        wr(9'h000, 4'hF, 32'h0000_0037);
        rd(9'h014, v); chk("R3 parity cleared by init", v, 32'h0);
        wr(9'h010, 4'hF, 32'h0403_0201);
        wr(9'h010, 4'hF, 32'h0807_0605);
        idle(2);
        chk("R6 clipped count", ncap - b0, 6);
        chk("R6 last clipped byte", {24'h0, cap[b0+5]}, 32'h06);
        chk("R6 clip start", nstart - s0, 1);
        eng_fin(1'b0, 1'b0, 7'd0, 7'd0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        int b0, s0;
        logic [7:0] exp_b [7] = '{8'hAA,8'hBB,8'hCC,8'hDD,8'h11,8'h22,8'h33};
        wr(9'h184, 4'hF, 32'hFFFF_FFFF);
        rd(9'h184, v); chk("R8 all cleared", v, 32'h0);
        wr(9'h00C, 4'hF, 32'h0003_0004);
        b0 = ncap; s0 = nstart;
        wr(9'h000, 4'hF, 32'h0000_0033);
        wr(9'h010, 4'hF, 32'hDDCC_BBAA);
        wr(9'h010, 4'b0001, 32'h0000_0011);
        wr(9'h010, 4'b0010, 32'h0000_2200);
        chk("R6 decode waits for parity", nstart - s0, 0);
        wr(9'h010, 4'b1000, 32'h3300_0000);
        idle(2);
        chk("R6 decode start", nstart - s0, 1);
        chk("R6 decode bytes", ncap - b0, 7);
        for (int i = 0; i < 7; i++) chk("R5 decode byte", {24'h0, cap[b0+i]}, {24'h0, exp_b[i]});
        eng_rep(0, 16'h0180, 11'd1);
        eng_rep(1, 16'h8000, 11'd3);
        eng_fin(1'b1, 1'b0, 7'd3, 7'd2);
        rd(9'h184, v); chk("R8 decode status", v, 32'h0203_0009);
        rd(9'h084, v); chk("R9 report0", v, 32'h0180_0001);
        rd(9'h088, v); chk("R9 report1", v, 32'h8000_0003);
        wr(9'h184, 4'hF, 32'h0000_0001);
        rd(9'h184, v); chk("R8 w1c single bit", v, 32'h0203_0008);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        chk("R11 irq off", {31'h0, irq}, 32'h0);
        wr(9'h188, 4'hF, 32'h0000_0008);
        @(negedge clk); chk("R11 irq on", {31'h0, irq}, 32'h1);
        rd(9'h190, v); chk("R11 ie read", v, 32'h8);
        wr(9'h18C, 4'hF, 32'h0000_0008);
        @(negedge clk); chk("R11 irq masked", {31'h0, irq}, 32'h0);
        wr(9'h188, 4'hF, 32'h0000_0008);
        wr(9'h184, 4'hF, 32'h0000_0008);
        @(negedge clk); chk("R11 irq after w1c", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        int b0;
        wr(9'h000, 4'b0001, 32'hFFFF_FFFF);
        rd(9'h000, v); chk("R1 low byte write", v, 32'h0000_00F5);
        wr(9'h000, 4'b0010, 32'h0000_0700);
        rd(9'h000, v); chk("R1 byte1 write", v, 32'h0000_07F5);
        wr(9'h008, 4'hF, 32'h0000_00A4);
        rd(9'h000, v); chk("R2 clear bits", v, 32'h0000_0751);
        wr(9'h008, 4'hF, 32'h0000_0001);
        rd(9'h000, v); chk("R10 disabled", v, 32'h0000_0750);
        b0 = ncap;
        wr(9'h010, 4'hF, 32'h1234_5678);
        wr(9'h010, 4'b0001, 32'h0000_0012);
        chk("R10 writes ignored", ncap - b0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_encode();
                t_clip_init();
                t_decode();
                t_irq();
                t_ctrl();
            end
            begin
                #500000;
                total++; bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule